// File: doc/BRIEF.md
# Carry-Gated Ripple ALU

This block is a purely combinational arithmetic logic unit of parameterised width. One chain of full-adder stages serves every operation. Three internal control bits steer it. An invert bit flips each bit of the second operand. A carry-enable bit ANDs the carry entering every stage, including bit zero. A seed bit supplies the carry into bit zero.

With the carry-enable low, each stage sees no carry, so the sum bits reduce to a bitwise exclusive-OR (or its complement). The same adder array therefore also provides the two logical operations. Callers do not drive the three control bits directly. A 3-bit operation code goes through a small decoder that emits only the six useful control patterns.

The second operand comes from one of two source buses. The source choice is folded into the same per-bit four-way selector that performs the conditional inversion, so it adds no extra mux level in front of the adder. Outputs are the N-bit result and a carry out. When subtracting, the carry out reads 1 for "no borrow".

Top module: `cg_ripple_alu`

## Requirements
- R1: Op code 0 (add) gives res_o = (a_i + B) mod 2^N and cout_o = 1 exactly when a_i + B >= 2^N, where B is the selected second operand.
- R2: Op code 1 (subtract) gives res_o = (a_i - B) mod 2^N, and cout_o = 1 exactly when a_i >= B (no borrow), 0 when a borrow occurs.
- R3: Op code 2 (add plus one) gives res_o = (a_i + B + 1) mod 2^N and cout_o = 1 exactly when a_i + B + 1 >= 2^N.
- R4: Op code 3 (subtract minus one) gives res_o = (a_i + ~B) mod 2^N, which equals a_i - B - 1, and cout_o = 1 exactly when a_i + ~B >= 2^N (that is, a_i > B).
- R5: Op code 4 (exclusive-OR) gives res_o = a_i ^ B and cout_o = 0 for every operand pair, including pairs with common set bits.
- R6: Op code 5 (equivalence) gives res_o = ~(a_i ^ B) and cout_o = 0 for every operand pair.
- R7: The unused op codes 6 and 7 produce exactly the output of op code 4.
- R8: When bsel_i is 0, B is b0_i and b1_i has no effect on either output; when bsel_i is 1, B is b1_i and b0_i has no effect.
- R9: Carries ripple across the full width: for an all-ones a_i, B = 0, op code 2 gives res_o = 0 and cout_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N | First operand |
| b0_i | input | N | Second-operand source 0 |
| b1_i | input | N | Second-operand source 1 |
| bsel_i | input | 1 | Selects source 1 when high, source 0 when low |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 add+1, 3 sub-1, 4 xor, 5 xnor, 6/7 as 4) |
| res_o | output | N | N-bit result |
| cout_o | output | 1 | Carry out of the most significant stage, after gating |

## Verification
The bench sweeps every opcode, source select and operand pair of a 4-bit instance, and adds random vectors on an 8-bit instance, against arithmetic computed in the bench.

It targets the following corner cases:
- Logical operations on operands with overlapping ones. An ungated carry out would show 1 here, and a stray carry would corrupt the result bits.
- Subtraction at equal operands and at a just-smaller minuend. An inverted borrow sense, or a missing +1, shows up at this boundary.
- The all-ones plus one ripple. A chain that drops the carry between stages would leave high bits set here.
- Toggling the unselected source while holding every other input. This exposes a selector that mixes the two buses.

// File: rtl/cg_alu_pkg.sv
package cg_alu_pkg;

  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_ADD   = 3'd0;
  localparam logic [OP_W-1:0] OP_SUB   = 3'd1;
  localparam logic [OP_W-1:0] OP_ADDP1 = 3'd2;
  localparam logic [OP_W-1:0] OP_SUBM1 = 3'd3;
  localparam logic [OP_W-1:0] OP_XOR   = 3'd4;
  localparam logic [OP_W-1:0] OP_XNOR  = 3'd5;

  // Internal steering of the adder array.
  typedef struct packed {
    logic seed;    // carry into bit zero
    logic cen;     // carry enable, ANDed into every stage
    logic inv;     // invert second operand
  } alu_ctrl_t;

endpackage

// File: rtl/cg_alu_decode.sv
module cg_alu_decode
  import cg_alu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output alu_ctrl_t       ctrl_o
);

  always_comb begin
    case (op_i)
      OP_ADD:   ctrl_o = '{seed: 1'b0, cen: 1'b1, inv: 1'b0};
      OP_SUB:   ctrl_o = '{seed: 1'b1, cen: 1'b1, inv: 1'b1};
      OP_ADDP1: ctrl_o = '{seed: 1'b1, cen: 1'b1, inv: 1'b0};
      OP_SUBM1: ctrl_o = '{seed: 1'b0, cen: 1'b1, inv: 1'b1};
      OP_XNOR:  ctrl_o = '{seed: 1'b0, cen: 1'b0, inv: 1'b1};
      default:  ctrl_o = '{seed: 1'b0, cen: 1'b0, inv: 1'b0};
    endcase
  end

  // The seed is meaningless without carry enable; only canonical patterns leave.
  always_comb begin
    AST_DEC_CANONICAL: assert (ctrl_o.cen || !ctrl_o.seed) else $error("seed without carry enable"); // R7
  end

endmodule

// File: rtl/cg_alu_bsel_inv.sv
module cg_alu_bsel_inv #(
  parameter int N = 8
) (
  input  logic [N-1:0] b0_i,
  input  logic [N-1:0] b1_i,
  input  logic         sel_i,
  input  logic         inv_i,
  output logic [N-1:0] bop_o
);

  localparam int CAND = 4;

  logic [1:0] pick;
  assign pick = {sel_i, inv_i};

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [CAND-1:0] cand;
    assign cand  = {~b1_i[i], b1_i[i], ~b0_i[i], b0_i[i]};
    assign bop_o[i] = cand[pick];
  end

  always_comb begin
    AST_BSEL_SRC: assert (bop_o == ((sel_i ? b1_i : b0_i) ^ {N{inv_i}})) else $error("operand select mismatch"); // R8
  end

endmodule

// File: rtl/cg_alu_chain.sv
module cg_alu_chain #(
  parameter int N = 8
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cen_i,
  input  logic         seed_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);

  logic [N:0] carry;
  assign carry[0] = seed_i;

  for (genvar i = 0; i < N; i++) begin : g_stage
    logic cin_g;
    assign cin_g      = cen_i & carry[i];
    assign sum_o[i]   = a_i[i] ^ b_i[i] ^ cin_g;
    assign carry[i+1] = (a_i[i] & b_i[i]) | (cin_g & (a_i[i] ^ b_i[i]));
  end

  assign cout_o = cen_i & carry[N];

  always_comb begin
    AST_CHAIN_NOCARRY: assert (cen_i || (sum_o == (a_i ^ b_i))) else $error("carry leaked with enable low"); // R5
  end

endmodule

// File: rtl/cg_ripple_alu.sv
module cg_ripple_alu
  import cg_alu_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]    a_i,
  input  logic [N-1:0]    b0_i,
  input  logic [N-1:0]    b1_i,
  input  logic            bsel_i,
  input  logic [OP_W-1:0] op_i,
  output logic [N-1:0]    res_o,
  output logic            cout_o
);

  localparam int SUM_W = N + 1;

  alu_ctrl_t   ctrl;
  logic [N-1:0] bop;

  cg_alu_decode u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  cg_alu_bsel_inv #(.N(N)) u_bsel (
    .b0_i  (b0_i),
    .b1_i  (b1_i),
    .sel_i (bsel_i),
    .inv_i (ctrl.inv),
    .bop_o (bop)
  );

  cg_alu_chain #(.N(N)) u_chain (
    .a_i    (a_i),
    .b_i    (bop),
    .cen_i  (ctrl.cen),
    .seed_i (ctrl.seed),
    .sum_o  (res_o),
    .cout_o (cout_o)
  );

  logic [N-1:0]     bsrc;
  logic [SUM_W-1:0] add_ref;
  assign bsrc    = bsel_i ? b1_i : b0_i;
  assign add_ref = {1'b0, a_i} + {1'b0, bsrc};

  always_comb begin
    AST_ADD_FULL: assert (op_i != OP_ADD || {cout_o, res_o} == add_ref) else $error("add mismatch"); // R1
    AST_SUB_NOBORROW: assert (op_i != OP_SUB || cout_o == (a_i >= bsrc)) else $error("borrow sense"); // R2
    AST_XNOR_RES: assert (op_i != OP_XNOR || (res_o == ~(a_i ^ bsrc) && !cout_o)) else $error("xnor mismatch"); // R6
    AST_XOR_NOCOUT: assert (op_i != OP_XOR || !cout_o) else $error("xor carry out"); // R5
  end

endmodule

// File: tb/cg_ripple_alu_bench.sv
module cg_ripple_alu_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // 4-bit instance for exhaustive sweep
  logic [3:0] a4, b04, b14, r4;
  logic       s4, c4;
  logic [2:0] op4;
  // 8-bit instance for random vectors
  logic [7:0] a8, b08, b18, r8;
  logic       s8, c8;
  logic [2:0] op8;

  cg_ripple_alu #(.N(4)) u_cg_ripple_alu_n4 (
    .a_i(a4), .b0_i(b04), .b1_i(b14), .bsel_i(s4), .op_i(op4), .res_o(r4), .cout_o(c4));

  cg_ripple_alu #(.N(8)) u_cg_ripple_alu (
    .a_i(a8), .b0_i(b08), .b1_i(b18), .bsel_i(s8), .op_i(op8), .res_o(r8), .cout_o(c8));

  function automatic logic [8:0] ref_op(input int op, input int a, input int b, input int n);
    int mask = (1 << n) - 1;
    int s;
    int r;
    int c;
    case (op)
      0: s = a + b;
      1: s = a + ((~b) & mask) + 1;
      2: s = a + b + 1;
      3: s = a + ((~b) & mask);
      5: s = (~(a ^ b)) & mask;
      default: s = a ^ b;
    endcase
    r = s & mask;
    c = (s >> n) & 1;
    return {c[0], r[7:0]};
  endfunction

  function automatic string tag(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic cmp(input string req, input int got_r, input int got_c, input logic [8:0] exp);
    n_checks++;
    if (got_r != int'(exp[7:0]) || got_c != int'(exp[8])) begin
      n_fail++;
      $display("FAIL %s: got res=%0h cout=%0d expected res=%0h cout=%0d",
               req, got_r, got_c, exp[7:0], exp[8]);
    end
  endtask

  task automatic drive4(input int op, input int a, input int b0, input int b1, input bit s);
    @(posedge clk);
    op4 = 3'(op); a4 = 4'(a); b04 = 4'(b0); b14 = 4'(b1); s4 = s;
    @(negedge clk);
  endtask

  initial begin
    op4 = '0; a4 = '0; b04 = '0; b14 = '0; s4 = 1'b0;
    op8 = '0; a8 = '0; b08 = '0; b18 = '0; s8 = 1'b0;
    @(negedge clk);
    // Initial all-zero add
    cmp("R1", int'(r4), int'(c4), 9'h000);
    cmp("R1", int'(r8), int'(c8), 9'h000);

    // Exhaustive 4-bit sweep, both sources, unselected source = complement
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int s = 0; s < 2; s++) begin
            drive4(op, a, s ? (~b & 15) : b, s ? b : (~b & 15), s[0]);
            cmp(tag(op), int'(r4), int'(c4), ref_op(op, a, b, 4));
            if (op >= 6) cmp("R7", int'(r4), int'(c4), ref_op(4, a, b, 4));
          end

    // R8: unselected source varied, output must stay put
    for (int op = 0; op < 8; op++)
      for (int k = 0; k < 16; k++) begin
        drive4(op, 9, 5, k, 1'b0);
        cmp("R8", int'(r4), int'(c4), ref_op(op, 9, 5, 4));
        drive4(op, 9, k, 6, 1'b1);
        cmp("R8", int'(r4), int'(c4), ref_op(op, 9, 6, 4));
      end

    // R9: full ripple
    drive4(2, 15, 0, 0, 1'b0);
    cmp("R9", int'(r4), int'(c4), 9'h100);
    @(posedge clk);
    op8 = 3'd2; a8 = 8'hFF; b08 = 8'h00; b18 = 8'h5A; s8 = 1'b0;
    @(negedge clk);
    cmp("R9", int'(r8), int'(c8), 9'h100);

    // R2 borrow boundary at 8 bits
    @(posedge clk);
    op8 = 3'd1; a8 = 8'h80; b08 = 8'h80; s8 = 1'b0;
    @(negedge clk);
    cmp("R2", int'(r8), int'(c8), 9'h100);
    @(posedge clk);
    a8 = 8'h7F;
    @(negedge clk);
    cmp("R2", int'(r8), int'(c8), 9'h0FF);

    // Random 8-bit vectors
    for (int i = 0; i < 2000; i++) begin
      int op = int'($urandom_range(7, 0));
      int a  = int'($urandom_range(255, 0));
      int b  = int'($urandom_range(255, 0));
      int o  = int'($urandom_range(255, 0));
      bit s  = 1'($urandom_range(1, 0));
      @(posedge clk);
      op8 = 3'(op); a8 = 8'(a); s8 = s;
      b08 = s ? 8'(o) : 8'(b);
      b18 = s ? 8'(b) : 8'(o);
      @(negedge clk);
      cmp(tag(op), int'(r8), int'(c8), ref_op(op, a, b, 8));
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule